// File: doc/BRIEF.md
# Shifter Operand Generator With Carry

This purely combinational block produces the second operand of a 32-bit data-processing operation, together with the carry that the shift stage passes on to the flags. It receives the instruction word, the value of the register to be shifted, the value of the register that holds a shift amount, the current carry flag, and one flag for each register value that says the register is the program counter.

Three operand forms are decoded from the instruction word:
- **Rotated 8-bit immediate**, selected by bit 25 set. The constant in bits 7:0 is rotated right by twice the 4-bit count in bits 11:8.
- **Shift by a 5-bit immediate amount**, selected by bit 25 clear and bit 4 clear. The amount sits in bits 11:7.
- **Shift by a register amount**, selected by bit 25 clear and bit 4 set. The amount is the low 8 bits of the amount register value. This form costs one extra cycle, and the block reports that cycle.

The shift kind is in bits 6:5: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. The register file and the ALU lie outside the block.

Top module: `shift_operand_gen`

## Requirements
- R1: With instr bit 25 = 1, operand = {24'b0, bits 7:0} rotated right by 2 x bits 11:8. Carry-out equals carry_i when bits 11:8 are zero, and operand bit 31 otherwise.
- R2: extra_cycle_o is 1 exactly when instr bit 25 = 0 and bit 4 = 1. It is 0 in both immediate forms.
- R3: In the register-amount form, a set src_pc_i adds 4 to the shifted value, and a set amt_pc_i adds 4 to the amount register before its low 8 bits are taken. In the immediate-amount form both flags have no effect.
- R4: In the register-amount form, an amount of 0 (after the low 8 bits are taken) returns the value unchanged and passes carry_i to carry-out, for every shift kind.
- R5: Logical left by register (kind 00):
  - amounts 1..31 shift normally, and carry is the last bit shifted out;
  - amount 32 gives 0 with carry = bit 0;
  - amounts above 32 give 0 with carry 0.
- R6: Logical right by register (kind 01):
  - amounts 1..31 shift normally, and carry is bit (amount-1);
  - amount 32 gives 0 with carry = bit 31;
  - amounts above 32 give 0 with carry 0.
- R7: Arithmetic right by register (kind 10):
  - amounts 1..31 shift in copies of the sign, and carry is bit (amount-1);
  - amounts of 32 or more give all sign bits, with carry = sign.
- R8: Rotate right by register (kind 11). The rotation is the low 5 bits of the amount, and carry is bit (rotation-1). A nonzero amount whose low 5 bits are zero returns the value unchanged with carry = bit 31.
- R9: Logical left by immediate amount 0 returns the value unchanged and keeps carry_i. Nonzero immediate amounts follow the rule in R5.
- R10: Logical right by immediate amount 0 means a shift by 32: the result is 0 and carry = bit 31. Nonzero immediate amounts shift normally.
- R11: Arithmetic right by immediate amount 0 gives all sign bits with carry = sign. Nonzero immediate amounts shift normally.
- R12: Rotate right by immediate amount 0 rotates one place through the carry: carry_i enters bit 31, and bit 0 becomes the carry-out. Nonzero immediate amounts rotate normally, with carry = bit (amount-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| src_val_i | input | 32 | Value of the register to be shifted |
| amt_val_i | input | 32 | Value of the register holding the shift amount |
| carry_i | input | 1 | Current carry flag |
| src_pc_i | input | 1 | The shifted register is the program counter |
| amt_pc_i | input | 1 | The amount register is the program counter |
| operand_o | output | 32 | Shifter operand |
| carry_o | output | 1 | Shifter carry-out |
| extra_cycle_o | output | 1 | The register-amount form needs one more cycle |

## Verification
The bench targets the amount boundaries 0, 1, 31, 32, 33 and above 255, together with rotations that are multiples of 32. A design that reduced the amount to 5 bits would return a shifted value instead of zero or sign fill. A design that dropped the immediate-zero reinterpretations would pass the value through where logical right must yield zero, arithmetic right must yield sign fill, and rotate must feed carry_i into bit 31. Further vectors check that the program-counter bias moves both the value and the amount in the register form, and that an 8-bit wrap of the amount to zero falls back to passthrough. They also check that the bias is ignored in the immediate form, and that the rotated-immediate carry is kept only when the rotation is zero.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  localparam int unsigned IMM_FORM_BIT = 25;
  localparam int unsigned REG_AMT_BIT  = 4;
  localparam int unsigned KIND_LSB     = 5;
  localparam int unsigned IMM5_LSB     = 7;
  localparam int unsigned IMM5_W       = 5;
  localparam int unsigned ROT_LSB      = 8;
  localparam int unsigned ROT_W        = 4;
  localparam int unsigned IMM8_W       = 8;
  localparam int unsigned PC_BIAS      = 4;
endpackage

// File: rtl/sop_decode.sv
`timescale 1ns/1ps
module sop_decode
  import sop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] src_val_i,
  input  logic [AMT_W-1:0]  amt_val_i,
  input  logic              src_pc_i,
  input  logic              amt_pc_i,
  output logic              imm_form_o,
  output shift_kind_e       kind_o,
  output logic [DATA_W-1:0] val_o,
  output logic [AMT_W-1:0]  amt_o,
  output logic              rrx_o,
  output logic              extra_cycle_o
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic              reg_form;
  logic [IMM5_W-1:0] imm5;

  assign imm_form_o    = instr_i[IMM_FORM_BIT];
  assign reg_form      = ~instr_i[IMM_FORM_BIT] & instr_i[REG_AMT_BIT];
  assign extra_cycle_o = reg_form;
  assign kind_o        = shift_kind_e'(instr_i[KIND_LSB +: 2]);
  assign imm5          = instr_i[IMM5_LSB +: IMM5_W];

  always_comb begin
    rrx_o = 1'b0;
    if (reg_form) begin
      val_o = src_val_i + (src_pc_i ? DATA_W'(PC_BIAS) : '0);
      amt_o = amt_val_i + (amt_pc_i ? AMT_W'(PC_BIAS) : '0);
    end else begin
      val_o = src_val_i;
      if (imm5 != '0) begin
        amt_o = AMT_W'(imm5);
      end else begin
        // immediate zero is reinterpreted per kind
        unique case (kind_o)
          SK_LSL: amt_o = '0;
          SK_LSR: amt_o = FULL_AMT;
          SK_ASR: amt_o = FULL_AMT;
          SK_ROR: begin
            amt_o = '0;
            rrx_o = 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sop_shift_lane.sv
`timescale 1ns/1ps
module sop_shift_lane
  import sop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8,
  parameter shift_kind_e KIND   = SK_LSL
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  input  logic              rrx_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [SH_W-1:0] sh;
  logic            amt_zero;

  assign sh       = amt_i[SH_W-1:0];
  assign amt_zero = (amt_i == '0);

  if (KIND == SK_LSL) begin : g_lsl
    logic [DATA_W:0] wide;
    logic            unused_rrx;
    assign unused_rrx = rrx_i;
    assign wide = {1'b0, val_i} << sh;
    always_comb begin
      if (amt_zero) begin
        res_o = val_i;   carry_o = carry_i;
      end else if (amt_i < FULL_AMT) begin
        res_o = wide[DATA_W-1:0]; carry_o = wide[DATA_W];
      end else if (amt_i == FULL_AMT) begin
        res_o = '0;      carry_o = val_i[0];
      end else begin
        res_o = '0;      carry_o = 1'b0;
      end
    end
  end else if (KIND == SK_LSR) begin : g_lsr
    logic [DATA_W:0] wide;
    logic            unused_rrx;
    assign unused_rrx = rrx_i;
    assign wide = {val_i, 1'b0} >> sh;
    always_comb begin
      if (amt_zero) begin
        res_o = val_i;   carry_o = carry_i;
      end else if (amt_i < FULL_AMT) begin
        res_o = wide[DATA_W:1]; carry_o = wide[0];
      end else if (amt_i == FULL_AMT) begin
        res_o = '0;      carry_o = val_i[DATA_W-1];
      end else begin
        res_o = '0;      carry_o = 1'b0;
      end
    end
  end else if (KIND == SK_ASR) begin : g_asr
    logic signed [DATA_W:0] wide;
    logic                   unused_rrx;
    assign unused_rrx = rrx_i;
    assign wide = $signed({val_i, 1'b0}) >>> sh;
    always_comb begin
      if (amt_zero) begin
        res_o = val_i;   carry_o = carry_i;
      end else if (amt_i < FULL_AMT) begin
        res_o = wide[DATA_W:1]; carry_o = wide[0];
      end else begin
        res_o = {DATA_W{val_i[DATA_W-1]}}; carry_o = val_i[DATA_W-1];
      end
    end
  end else begin : g_ror
    logic [DATA_W-1:0] rot;
    assign rot = (val_i >> sh) | (val_i << (DATA_W - int'(sh)));
    always_comb begin
      if (rrx_i) begin
        res_o = {carry_i, val_i[DATA_W-1:1]}; carry_o = val_i[0];
      end else if (amt_zero) begin
        res_o = val_i;   carry_o = carry_i;
      end else begin
        // last bit rotated out lands in the msb
        res_o = rot;     carry_o = rot[DATA_W-1];
      end
    end
  end
endmodule

// File: rtl/sop_rot_imm.sv
`timescale 1ns/1ps
module sop_rot_imm
  import sop_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [ROT_W-1:0]  rot_i,
  input  logic [IMM8_W-1:0] imm8_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int unsigned RA_W = ROT_W + 1;

  logic [RA_W-1:0]   ra;
  logic [DATA_W-1:0] base;

  assign ra      = {rot_i, 1'b0};
  assign base    = DATA_W'(imm8_i);
  assign res_o   = (base >> ra) | (base << (DATA_W - int'(ra)));
  assign carry_o = (rot_i == '0) ? carry_i : res_o[DATA_W-1];
endmodule

// File: rtl/shift_operand_gen.sv
`timescale 1ns/1ps
module shift_operand_gen
  import sop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] src_val_i,
  input  logic [DATA_W-1:0] amt_val_i,
  input  logic              carry_i,
  input  logic              src_pc_i,
  input  logic              amt_pc_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o,
  output logic              extra_cycle_o
);
  localparam int unsigned N_KIND = 4;

  logic              imm_form;
  shift_kind_e       kind;
  logic [DATA_W-1:0] val;
  logic [AMT_W-1:0]  amt;
  logic              rrx;
  logic [DATA_W-1:0] lane_res [N_KIND];
  logic              lane_c   [N_KIND];
  logic [DATA_W-1:0] ri_res;
  logic              ri_c;
  logic              unused_bits;

  assign unused_bits = ^{instr_i[31:26], instr_i[24:12], instr_i[3:0],
                         amt_val_i[DATA_W-1:AMT_W]};

  sop_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .instr_i      (instr_i),
    .src_val_i    (src_val_i),
    .amt_val_i    (amt_val_i[AMT_W-1:0]),
    .src_pc_i     (src_pc_i),
    .amt_pc_i     (amt_pc_i),
    .imm_form_o   (imm_form),
    .kind_o       (kind),
    .val_o        (val),
    .amt_o        (amt),
    .rrx_o        (rrx),
    .extra_cycle_o(extra_cycle_o)
  );

  for (genvar k = 0; k < N_KIND; k++) begin : g_lane
    sop_shift_lane #(
      .DATA_W(DATA_W), .AMT_W(AMT_W), .KIND(shift_kind_e'(k))
    ) u_lane (
      .val_i  (val),
      .amt_i  (amt),
      .carry_i(carry_i),
      .rrx_i  (rrx),
      .res_o  (lane_res[k]),
      .carry_o(lane_c[k])
    );
  end

  sop_rot_imm #(.DATA_W(DATA_W)) u_rimm (
    .rot_i  (instr_i[ROT_LSB +: ROT_W]),
    .imm8_i (instr_i[IMM8_W-1:0]),
    .carry_i(carry_i),
    .res_o  (ri_res),
    .carry_o(ri_c)
  );

  always_comb begin
    if (imm_form) begin
      operand_o = ri_res;
      carry_o   = ri_c;
    end else begin
      operand_o = lane_res[kind];
      carry_o   = lane_c[kind];
    end
  end
endmodule

// File: rtl/shift_operand_gen_chk.sv
`timescale 1ns/1ps
module shift_operand_gen_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic [31:0]       instr_i,
  input logic [DATA_W-1:0] src_val_i,
  input logic [DATA_W-1:0] amt_val_i,
  input logic              carry_i,
  input logic              src_pc_i,
  input logic              amt_pc_i,
  input logic [DATA_W-1:0] operand_o,
  input logic              carry_o,
  input logic              extra_cycle_o
);
  logic       imm_f, reg_f, shi_f, known;
  logic [1:0] kd;
  logic [7:0] ramt;
  logic [4:0] imm5;
  logic [DATA_W-1:0] rval;
  logic       unused_chk;

  assign unused_chk = ^{instr_i[31:26], instr_i[24:12], instr_i[3:0],
                        amt_val_i[DATA_W-1:8]};
  assign imm_f = instr_i[25];
  assign reg_f = ~instr_i[25] & instr_i[4];
  assign shi_f = ~instr_i[25] & ~instr_i[4];
  assign kd    = instr_i[6:5];
  assign imm5  = instr_i[11:7];
  assign ramt  = amt_val_i[7:0] + (amt_pc_i ? 8'd4 : 8'd0);
  assign rval  = src_val_i + (src_pc_i ? DATA_W'(4) : '0);
  assign known = !$isunknown({instr_i, src_val_i, amt_val_i, carry_i, src_pc_i,
                              amt_pc_i, operand_o, carry_o, extra_cycle_o});

  always_comb begin
    if (known) begin
      a_r1_zero_rot_keeps_carry: assert (!(imm_f && instr_i[11:8] == 4'd0) ||
        (operand_o == DATA_W'(instr_i[7:0]) && carry_o == carry_i))
        else $error("a_r1_zero_rot_keeps_carry");
      a_r1_rot_carry_msb: assert (!(imm_f && instr_i[11:8] != 4'd0) ||
        carry_o == operand_o[DATA_W-1])
        else $error("a_r1_rot_carry_msb");
      a_r2_no_extra_imm: assert (!(imm_f || shi_f) || !extra_cycle_o)
        else $error("a_r2_no_extra_imm");
      a_r4_reg_zero_pass: assert (!(reg_f && ramt == 8'd0) ||
        (operand_o == rval && carry_o == carry_i))
        else $error("a_r4_reg_zero_pass");
      a_r5_lsl_beyond: assert (!(reg_f && kd == 2'b00 && ramt > 8'd32) ||
        (operand_o == '0 && !carry_o))
        else $error("a_r5_lsl_beyond");
      a_r7_asr_fill: assert (!(reg_f && kd == 2'b10 && ramt >= 8'd32) ||
        (operand_o == {DATA_W{rval[DATA_W-1]}} && carry_o == rval[DATA_W-1]))
        else $error("a_r7_asr_fill");
      a_r8_ror_wrap: assert (!(reg_f && kd == 2'b11 && ramt != 8'd0 && ramt[4:0] == 5'd0) ||
        (operand_o == rval && carry_o == rval[DATA_W-1]))
        else $error("a_r8_ror_wrap");
      a_r10_lsr_imm0: assert (!(shi_f && kd == 2'b01 && imm5 == 5'd0) ||
        (operand_o == '0 && carry_o == src_val_i[DATA_W-1]))
        else $error("a_r10_lsr_imm0");
      a_r11_asr_imm0: assert (!(shi_f && kd == 2'b10 && imm5 == 5'd0) ||
        (operand_o == {DATA_W{src_val_i[DATA_W-1]}} && carry_o == src_val_i[DATA_W-1]))
        else $error("a_r11_asr_imm0");
      a_r12_rrx: assert (!(shi_f && kd == 2'b11 && imm5 == 5'd0) ||
        (operand_o == {carry_i, src_val_i[DATA_W-1:1]} && carry_o == src_val_i[0]))
        else $error("a_r12_rrx");
    end
  end
endmodule

bind shift_operand_gen shift_operand_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .instr_i      (instr_i),
  .src_val_i    (src_val_i),
  .amt_val_i    (amt_val_i),
  .carry_i      (carry_i),
  .src_pc_i     (src_pc_i),
  .amt_pc_i     (amt_pc_i),
  .operand_o    (operand_o),
  .carry_o      (carry_o),
  .extra_cycle_o(extra_cycle_o)
);

// File: tb/shift_operand_gen_tb_top.sv
`timescale 1ns/1ps
module shift_operand_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0, src = '0, amt = '0;
  logic        cin = 1'b0, spc = 1'b0, apc = 1'b0;
  logic [31:0] op;
  logic        cout, xcyc;
  int          n_vec = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  shift_operand_gen dut_i (
    .instr_i(instr), .src_val_i(src), .amt_val_i(amt), .carry_i(cin),
    .src_pc_i(spc), .amt_pc_i(apc),
    .operand_o(op), .carry_o(cout), .extra_cycle_o(xcyc)
  );

  function automatic logic [31:0] f_rimm(input logic [3:0] r, input logic [7:0] v);
    return 32'h0200_0000 | (32'(r) << 8) | 32'(v);
  endfunction
  function automatic logic [31:0] f_shi(input logic [1:0] k, input logic [4:0] a);
    return (32'(a) << 7) | (32'(k) << 5);
  endfunction
  function automatic logic [31:0] f_shr(input logic [1:0] k);
    return 32'h0000_0310 | (32'(k) << 5);
  endfunction

  task automatic run(input string req, input logic [31:0] i, input logic [31:0] s,
                     input logic [31:0] a, input logic c, input logic sp, input logic ap,
                     input logic [31:0] e_op, input logic e_c, input logic e_x);
    @(negedge clk);
    instr = i; src = s; amt = a; cin = c; spc = sp; apc = ap;
    @(posedge clk); #1;
    n_vec++;
    if (op !== e_op || cout !== e_c || xcyc !== e_x) begin
      n_bad++;
      $display("FAIL %s op=%h/%h carry=%b/%b extra=%b/%b (actual/expected)",
               req, op, e_op, cout, e_c, xcyc, e_x);
    end
  endtask

  task automatic t_reset;
    run("R2 reset", 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask
  task automatic t_r1;
    run("R1 rot0", f_rimm(4'd0, 8'hAB), 0, 0, 1, 0, 0, 32'h0000_00AB, 1, 0);
    run("R1 rot8", f_rimm(4'd4, 8'hFF), 0, 0, 0, 0, 0, 32'hFF00_0000, 1, 0);
    run("R1 rot2", f_rimm(4'd1, 8'h03), 0, 0, 0, 0, 0, 32'hC000_0000, 1, 0);
    run("R1 rot16", f_rimm(4'd8, 8'h01), 0, 0, 1, 0, 0, 32'h0001_0000, 0, 0);
  endtask
  task automatic t_r2;
    run("R2 reg extra", f_shr(2'b00), 32'h1, 32'h1, 0, 0, 0, 32'h2, 0, 1);
    run("R2 imm none", f_shi(2'b00, 5'd1), 32'h1, 32'h1, 0, 0, 0, 32'h2, 0, 0);
  endtask
  task automatic t_r3;
    run("R3 src bias", f_shr(2'b00), 32'h10, 32'h1, 0, 1, 0, 32'h28, 0, 1);
    run("R3 amt wrap", f_shr(2'b00), 32'h1234_5678, 32'hFC, 1, 0, 1, 32'h1234_5678, 1, 1);
    run("R3 amt bias", f_shr(2'b01), 32'h100, 32'h0, 0, 0, 1, 32'h10, 0, 1);
    run("R3 imm ignores", f_shi(2'b00, 5'd1), 32'h10, 32'h0, 0, 1, 1, 32'h20, 0, 0);
  endtask
  task automatic t_r4;
    run("R4 ror 256", f_shr(2'b11), 32'h8000_0001, 32'h100, 0, 0, 0, 32'h8000_0001, 0, 1);
    run("R4 lsr 0", f_shr(2'b01), 32'hFFFF_0000, 32'h0, 1, 0, 0, 32'hFFFF_0000, 1, 1);
    run("R4 asr 0", f_shr(2'b10), 32'h8000_0000, 32'hF00, 0, 0, 0, 32'h8000_0000, 0, 1);
  endtask
  task automatic t_r5;
    run("R5 lsl 4", f_shr(2'b00), 32'hF000_0001, 4, 0, 0, 0, 32'h0000_0010, 1, 1);
    run("R5 lsl 31", f_shr(2'b00), 32'h3, 31, 0, 0, 0, 32'h8000_0000, 1, 1);
    run("R5 lsl 32", f_shr(2'b00), 32'h1, 32, 0, 0, 0, 32'h0, 1, 1);
    run("R5 lsl 33", f_shr(2'b00), 32'hFFFF_FFFF, 33, 1, 0, 0, 32'h0, 0, 1);
  endtask
  task automatic t_r6;
    run("R6 lsr 4", f_shr(2'b01), 32'h1F, 4, 0, 0, 0, 32'h1, 1, 1);
    run("R6 lsr 32", f_shr(2'b01), 32'h8000_0000, 32, 0, 0, 0, 32'h0, 1, 1);
    run("R6 lsr 200", f_shr(2'b01), 32'hFFFF_FFFF, 200, 1, 0, 0, 32'h0, 0, 1);
  endtask
  task automatic t_r7;
    run("R7 asr 4", f_shr(2'b10), 32'h8000_0008, 4, 0, 0, 0, 32'hF800_0000, 1, 1);
    run("R7 asr 32", f_shr(2'b10), 32'h8000_0000, 32, 0, 0, 0, 32'hFFFF_FFFF, 1, 1);
    run("R7 asr 255", f_shr(2'b10), 32'h7FFF_FFFF, 255, 1, 0, 0, 32'h0, 0, 1);
  endtask
  task automatic t_r8;
    run("R8 ror 4", f_shr(2'b11), 32'h1F, 4, 0, 0, 0, 32'hF000_0001, 1, 1);
    run("R8 ror 36", f_shr(2'b11), 32'h1F, 36, 0, 0, 0, 32'hF000_0001, 1, 1);
    run("R8 ror 32", f_shr(2'b11), 32'h8000_0000, 32, 0, 0, 0, 32'h8000_0000, 1, 1);
    run("R8 ror 64", f_shr(2'b11), 32'h7FFF_FFFF, 64, 1, 0, 0, 32'h7FFF_FFFF, 0, 1);
  endtask
  task automatic t_r9;
    run("R9 lsl #0 c1", f_shi(2'b00, 5'd0), 32'hDEAD_BEEF, 0, 1, 0, 0, 32'hDEAD_BEEF, 1, 0);
    run("R9 lsl #0 c0", f_shi(2'b00, 5'd0), 32'hDEAD_BEEF, 0, 0, 0, 0, 32'hDEAD_BEEF, 0, 0);
    run("R9 lsl #31", f_shi(2'b00, 5'd31), 32'h3, 0, 0, 0, 0, 32'h8000_0000, 1, 0);
  endtask
  task automatic t_r10;
    run("R10 lsr #0 hi", f_shi(2'b01, 5'd0), 32'h8000_0000, 0, 0, 0, 0, 32'h0, 1, 0);
    run("R10 lsr #0 lo", f_shi(2'b01, 5'd0), 32'h7FFF_FFFF, 0, 1, 0, 0, 32'h0, 0, 0);
    run("R10 lsr #1", f_shi(2'b01, 5'd1), 32'h3, 0, 0, 0, 0, 32'h1, 1, 0);
  endtask
  task automatic t_r11;
    run("R11 asr #0 neg", f_shi(2'b10, 5'd0), 32'h8000_0000, 0, 0, 0, 0, 32'hFFFF_FFFF, 1, 0);
    run("R11 asr #0 pos", f_shi(2'b10, 5'd0), 32'h4000_0000, 0, 1, 0, 0, 32'h0, 0, 0);
    run("R11 asr #31", f_shi(2'b10, 5'd31), 32'h8000_0000, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0);
  endtask
  task automatic t_r12;
    run("R12 rrx c1", f_shi(2'b11, 5'd0), 32'h3, 0, 1, 0, 0, 32'h8000_0001, 1, 0);
    run("R12 rrx c0", f_shi(2'b11, 5'd0), 32'h2, 0, 0, 0, 0, 32'h1, 0, 0);
    run("R12 ror #8", f_shi(2'b11, 5'd8), 32'h1234_5678, 0, 1, 0, 0, 32'h7812_3456, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset(); t_r1(); t_r2(); t_r3(); t_r4(); t_r5(); t_r6();
    t_r7(); t_r8(); t_r9(); t_r10(); t_r11(); t_r12();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule